// File: doc/BRIEF.md
# I2C Register Slave with Page Writes

This block is a two-wire serial slave that gives byte access to a 256-location register space. The lower half (00h-7Fh) is one flat region. The upper half (80h-FFh) is banked: an external 4-bit select field picks one of four tables. SCL and SDA arrive as raw bus levels. They are resynchronised to the system clock, which must run at least 16 times faster than SCL. The block drives SDA only through an open-drain pull-down enable.

A write transaction has three parts: the device address byte, a byte that loads the internal pointer, and then data bytes. The data bytes are collected in an 8-entry page buffer. The pointer wraps inside the aligned 8-byte page, so the last eight bytes sent are the ones kept. After STOP, the buffered bytes go out on the register port, one strobe per clock. Reads begin at the current pointer and step through the whole space, wrapping from FFh to 00h.

While an external nonvolatile write is in progress, the slave refuses to acknowledge its own address, so a master can poll it until it answers. A bus-active output lets neighbouring logic hold off its own memory traffic while a transaction is open.

Top module: `i2c_regslave`

## Requirements
- R1: The 7-bit device address is 1,0,1,1,0,A1,A0, where A1 and A0 come from `dev_pins_i[1]` and `dev_pins_i[0]`. It is followed by the R/W bit (1 = read), all most significant bit first. So with the pins at 00 the write byte is B0h and the read byte is B1h. On a match the slave acknowledges by pulling SDA low during the 9th clock.
- R2: After an address byte that does not match, the slave acknowledges nothing, never pulls SDA low and issues no register write until the next START.
- R3: In a write, the first byte after the address byte loads the pointer. Each later byte is stored at the pointer, and the pointer then advances. Each byte is acknowledged.
- R4: During a write, the pointer wraps within its aligned 8-byte page (bits 2:0 roll over, bits 7:3 are kept). When more than 8 data bytes are sent, only the last 8 written to each offset are kept.
- R5: A read returns the byte at the pointer and then the following bytes, wrapping from FFh to 00h. A NACK from the master ends the read, and SDA is released.
- R6: `bus_active_o` is high from a START to the following STOP and low after reset.
- R7: While `nv_busy_i` is high, the slave does not acknowledge its own address.
- R8: For addresses 80h-FFh, a select value of 4 to 7 routes the access to table `reg_tbl_o = select - 4`. With any other select value, upper-half writes produce no `reg_we_o` strobe and upper-half reads return FFh. Lower-half accesses ignore the select.
- R9: Buffered bytes are written only after STOP, with no strobe before it. They are issued one per clock, in ascending page-offset order, with `reg_addr_o = {page, offset}`.
- R10: Received bits are sampled on the rising edge of SCL. The SDA drive changes only after a falling edge of SCL, or when a START or STOP releases it.
- R11: A repeated START ends a dummy write that has set the pointer. The following read starts from that pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL bus level |
| sda_i | input | 1 | Raw SDA bus level |
| dev_pins_i | input | 2 | Address pins {A1, A0} |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | 8 | Register address, for reads and for commit writes |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Write strobe, one byte per clock |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational |
| tbl_sel_i | input | 4 | Table select field |
| reg_tbl_o | output | 2 | Selected table index for upper-half accesses |
| bus_active_o | output | 1 | High between START and STOP |
| nv_busy_i | input | 1 | Nonvolatile write in progress |

## Verification
The hardest case to reach from the ports is an over-long page write: data that crosses the page end and then overwrites offsets it already filled. Only the final contents of each offset may be committed, and only after STOP. The stimulus sends ten bytes starting two below the page end. A queue of expected commit writes is compared on every clock against the register strobe. A repeated-START readback then confirms the page contents. Read wrap across FFh is reached by writing the top and bottom of the space first and then reading across the boundary.

// File: rtl/i2c_regslave_pkg.sv
// Shared types for the I2C register slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_regslave_pkg;

    // Protocol phases of the slave engine.
    typedef enum logic [2:0] {
        S_IDLE,   // ignoring the bus until START
        S_DEV,    // receiving the device address byte
        S_WADR,   // receiving the pointer byte
        S_WDAT,   // receiving data bytes
        S_ACK,    // driving the acknowledge bit of a received byte
        S_RDAT,   // shifting a read byte out
        S_RACK    // waiting for the master's acknowledge
    } phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Resynchronises one bus line and flags its edges.
// Assumes: the line idles high; the clock runs well above the line's toggle rate.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    // pipe[STAGES-1:0] is the synchroniser; pipe[STAGES] holds the previous level
    logic [STAGES:0] pipe;

    // shift the raw level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], line_i};
    end

    // level and single-cycle edge flags
    always_comb begin
        lvl_o  = pipe[STAGES-1];
        rise_o = pipe[STAGES-1] & ~pipe[STAGES];
        fall_o = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/i2c_page_buf.sv
// Holds up to one page of received bytes and, on request, writes the filled
// entries out one per clock in ascending offset order.
// Assumes: store_i and commit_i are never high in the same cycle.
module i2c_page_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     store_i,
    input  logic [PAGE_W-1:0]        idx_i,
    input  logic [DATA_W-1:0]        data_i,
    input  logic [ADDR_W-PAGE_W-1:0] base_i,
    input  logic                     commit_i,
    output logic                     we_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [DATA_W-1:0]        data_o,
    output logic                     busy_o
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam logic [PAGE_W-1:0] LAST = PAGE_W'(PAGE_N - 1);

    logic [DATA_W-1:0]        ent [PAGE_N];
    logic [PAGE_N-1:0]        vld;
    logic [ADDR_W-PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0]        scan;
    logic                     run;

    // capture bytes, and scan the entries out after a commit request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= '0;
            base_q <= '0;
            scan   <= '0;
            run    <= 1'b0;
        end else if (store_i) begin
            ent[idx_i] <= data_i;
            vld[idx_i] <= 1'b1;
            base_q     <= base_i;
        end else if (commit_i && !run) begin
            run  <= 1'b1;
            scan <= '0;
        end else if (run) begin
            vld[scan] <= 1'b0;
            scan      <= scan + 1'b1;
            if (scan == LAST) run <= 1'b0;
        end
    end

    // present the entry under the scan pointer
    always_comb begin
        we_o   = run && vld[scan];
        addr_o = {base_q, scan};
        data_o = ent[scan];
        busy_o = run;
    end
endmodule

// File: rtl/i2c_regslave.sv
// Two-wire register slave: address match, pointer, buffered page writes,
// auto-incrementing reads and a banked upper half.
// Assumes: clk >= 16x SCL; reg_rdata_i is valid in the same cycle as reg_addr_o.
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          PAGE_W    = 3,
    parameter int          SYNC_N    = 2,
    parameter logic [4:0]  DEV_HI    = 5'b10110,
    parameter int          TBL_SEL_W = 4,
    parameter int          TBL_BASE  = 4,
    parameter int          TBL_N     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic [1:0]               dev_pins_i,
    output logic                     sda_oe_o,
    output logic [ADDR_W-1:0]        reg_addr_o,
    output logic [DATA_W-1:0]        reg_wdata_o,
    output logic                     reg_we_o,
    input  logic [DATA_W-1:0]        reg_rdata_i,
    input  logic [TBL_SEL_W-1:0]     tbl_sel_i,
    output logic [$clog2(TBL_N)-1:0] reg_tbl_o,
    output logic                     bus_active_o,
    input  logic                     nv_busy_i
);
    localparam int TBL_IDX_W = $clog2(TBL_N);
    localparam int CNT_W     = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(DATA_W - 1);
    localparam logic [TBL_SEL_W-1:0] TBL_BASE_V = TBL_SEL_W'(TBL_BASE);

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    phase_t              st, ack_nxt;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   sh;
    logic [ADDR_W-1:0]   ptr;
    logic                oe_q, bus_q;

    logic                store;
    logic                pb_we, pb_busy;
    logic [ADDR_W-1:0]   pb_addr;
    logic [DATA_W-1:0]   pb_data;
    logic [TBL_SEL_W-1:0] tbl_off;
    logic                tbl_ok, upper;
    logic [DATA_W-1:0]   rd_byte;
    logic                dev_hit;

    i2c_line_sync #(.STAGES(SYNC_N)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    i2c_line_sync #(.STAGES(SYNC_N)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    // bus conditions: SDA moving while SCL is high
    always_comb begin
        start_det = sda_fall && scl_lvl;
        stop_det  = sda_rise && scl_lvl;
        dev_hit   = (sh[DATA_W-1:1] == {DEV_HI, dev_pins_i});
        store     = (st == S_WDAT) && scl_fall && (cnt == BITS_FULL)
                    && !start_det && !stop_det;
    end

    i2c_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n),
        .store_i(store), .idx_i(ptr[PAGE_W-1:0]), .data_i(sh),
        .base_i(ptr[ADDR_W-1:PAGE_W]), .commit_i(stop_det),
        .we_o(pb_we), .addr_o(pb_addr), .data_o(pb_data), .busy_o(pb_busy));

    // register port: address mux, table routing and write gating
    always_comb begin
        reg_addr_o  = pb_busy ? pb_addr : ptr;
        upper       = reg_addr_o[ADDR_W-1];
        tbl_off     = tbl_sel_i - TBL_BASE_V;
        tbl_ok      = (tbl_off < TBL_SEL_W'(TBL_N));
        reg_tbl_o   = tbl_off[TBL_IDX_W-1:0];
        reg_we_o    = pb_we && (!upper || tbl_ok);
        reg_wdata_o = pb_data;
        rd_byte     = (upper && !tbl_ok) ? '1 : reg_rdata_i;
        sda_oe_o    = oe_q;
        bus_active_o = bus_q;
    end

    // protocol engine: bit counting, acknowledge, pointer and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            ack_nxt <= S_IDLE;
            cnt     <= '0;
            sh      <= '0;
            ptr     <= '0;
            oe_q    <= 1'b0;
            bus_q   <= 1'b0;
        end else if (start_det) begin
            st    <= S_DEV;
            cnt   <= '0;
            oe_q  <= 1'b0;
            bus_q <= 1'b1;
        end else if (stop_det) begin
            st    <= S_IDLE;
            oe_q  <= 1'b0;
            bus_q <= 1'b0;
        end else begin
            case (st)
                S_DEV, S_WADR, S_WDAT: begin
                    if (scl_rise && cnt != BITS_FULL) begin
                        sh  <= {sh[DATA_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == BITS_FULL) begin
                        cnt <= '0;
                        if (st == S_DEV) begin
                            if (dev_hit && !nv_busy_i && !pb_busy) begin
                                oe_q    <= 1'b1;
                                st      <= S_ACK;
                                ack_nxt <= sh[0] ? S_RDAT : S_WADR;
                            end else begin
                                st <= S_IDLE;
                            end
                        end else begin
                            if (st == S_WADR) ptr <= sh;
                            else ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                            oe_q    <= 1'b1;
                            st      <= S_ACK;
                            ack_nxt <= S_WDAT;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        st  <= ack_nxt;
                        cnt <= '0;
                        if (ack_nxt == S_RDAT) begin
                            sh   <= rd_byte;
                            oe_q <= ~rd_byte[DATA_W-1];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                S_RDAT: begin
                    if (scl_fall) begin
                        if (cnt == BITS_LAST) begin
                            oe_q <= 1'b0;
                            st   <= S_RACK;
                            ptr  <= ptr + 1'b1;
                            cnt  <= '0;
                        end else begin
                            sh   <= {sh[DATA_W-2:0], 1'b0};
                            oe_q <= ~sh[DATA_W-2];
                            cnt  <= cnt + 1'b1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise && sda_lvl) begin
                        st <= S_IDLE;
                    end else if (scl_fall) begin
                        sh   <= rd_byte;
                        oe_q <= ~rd_byte[DATA_W-1];
                        st   <= S_RDAT;
                        cnt  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
// Protocol checker for i2c_regslave, attached to every instance by bind.
// Assumes: connected by name to the top module's ports and internal nets.
module i2c_regslave_chk
    import i2c_regslave_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   sda_oe_o,
    input logic   bus_active_o,
    input logic   reg_we_o,
    input logic   nv_busy_i,
    input logic   scl_fall,
    input logic   start_det,
    input logic   stop_det,
    input phase_t st
);
    // R6
    bus_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_active_o) |-> $past(start_det));

    // R2
    oe_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> bus_active_o);

    // R9
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> !bus_active_o);

    // R10
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && $past(st == S_DEV)) |-> !$past(nv_busy_i));
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (.*);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] pins = 2'b00;
    logic [3:0] tsel = 4'd4;
    logic       nvb = 1'b0;
    wire        sda_oe;
    wire [7:0]  raddr, wdata, rdata;
    wire        we, busact;
    wire [1:0]  rtbl;
    wire        sda_line = m_sda & ~sda_oe;

    logic [7:0] lo  [0:127];
    logic [7:0] tbm [0:3][0:127];
    logic [7:0] elo [0:127];
    logic [7:0] etb [0:3][0:127];
    logic [17:0] wq[$];
    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];
    int checks = 0, fails = 0, we_cnt = 0;
    logic oe_seen = 1'b0;

    always #2 clk = ~clk;

    i2c_regslave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .dev_pins_i(pins), .sda_oe_o(sda_oe), .reg_addr_o(raddr),
        .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata),
        .tbl_sel_i(tsel), .reg_tbl_o(rtbl), .bus_active_o(busact),
        .nv_busy_i(nvb));

    assign rdata = raddr[7] ? tbm[rtbl][raddr[6:0]] : lo[raddr[6:0]];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // device-side storage written by the strobe
    always @(posedge clk) begin
        if (we) begin
            if (raddr[7]) tbm[rtbl][raddr[6:0]] <= wdata;
            else lo[raddr[6:0]] <= wdata;
        end
        if (sda_oe) oe_seen <= 1'b1;
    end

    // every-clock comparison of commit strobes against the expected queue (R9)
    always @(negedge clk) begin
        if (rst_n && we) begin
            we_cnt++;
            if (wq.size() == 0) chk(1'b0, "R9 unexpected write", {raddr, wdata}, 0);
            else begin
                logic [17:0] e;
                e = wq.pop_front();
                chk(e == {(raddr[7] ? rtbl : 2'd0), raddr, wdata}, "R9 commit order/data",
                    {(raddr[7] ? rtbl : 2'd0), raddr, wdata}, e);
            end
        end
    end

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic i_start;
        m_sda = 1'b1; wait_c(Q); m_scl = 1'b1; wait_c(Q);
        m_sda = 1'b0; wait_c(Q); m_scl = 1'b0; wait_c(Q);
    endtask
    task automatic i_stop;
        m_sda = 1'b0; wait_c(Q); m_scl = 1'b1; wait_c(Q);
        m_sda = 1'b1; wait_c(2*Q);
    endtask
    task automatic wbit(input logic b);
        m_sda = b; wait_c(Q); m_scl = 1'b1; wait_c(2*Q); m_scl = 1'b0; wait_c(Q);
    endtask
    task automatic rbit(output logic b);
        m_sda = 1'b1; wait_c(Q); m_scl = 1'b1; wait_c(Q);
        b = sda_line; wait_c(Q); m_scl = 1'b0; wait_c(Q);
    endtask
    task automatic wbyte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = !a;
    endtask
    task automatic rbyte(input bit ackit, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(!ackit);
    endtask

    function automatic bit tv(input logic [3:0] s);
        return s >= 4 && s <= 7;
    endfunction

    // write transaction with model: page wrap and commit list in offset order
    task automatic wr_txn(input logic [7:0] dev, input logic [7:0] a, input int n);
        bit ack;
        logic [7:0] pd [0:7];
        bit pv [0:7];
        int p, wc0;
        for (int i = 0; i < 8; i++) pv[i] = 0;
        i_start;
        chk(busact == 1'b1, "R6 active after START", busact, 1);
        wbyte(dev, ack); chk(ack, "R1 address ack", ack, 1);
        wbyte(a, ack);   chk(ack, "R3 pointer ack", ack, 1);
        p = a[2:0];
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack); chk(ack, "R3 data ack", ack, 1);
            pd[p] = wbuf[i]; pv[p] = 1; p = (p + 1) % 8;
        end
        wc0 = we_cnt;
        for (int i = 0; i < 8; i++)
            if (pv[i] && (!a[7] || tv(tsel))) begin
                wq.push_back({(a[7] ? 2'(tsel - 4) : 2'd0), a[7:3], 3'(i), pd[i]});
                if (a[7]) etb[2'(tsel - 4)][{a[6:3], 3'(i)}] = pd[i];
                else elo[{a[6:3], 3'(i)}] = pd[i];
            end
        chk(we_cnt == wc0, "R9 no strobe before STOP", we_cnt, wc0);
        i_stop;
        chk(busact == 1'b0, "R6 idle after STOP", busact, 0);
        wait_c(20);
        chk(wq.size() == 0, "R9 all commits issued", wq.size(), 0);
    endtask

    // dummy write then repeated-START read of n bytes
    task automatic rd_txn(input logic [7:0] dev, input logic [7:0] a, input int n, input string req);
        bit ack;
        logic [7:0] v;
        i_start;
        wbyte(dev, ack); chk(ack, "R11 dummy write ack", ack, 1);
        wbyte(a, ack);
        i_start;
        wbyte(dev | 8'h01, ack); chk(ack, "R11 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, v);
            chk(v == rbuf[i], req, v, rbuf[i]);
        end
        chk(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
        i_stop;
    endtask

    function automatic logic [7:0] emem(input logic [7:0] a);
        if (!a[7]) return elo[a[6:0]];
        if (!tv(tsel)) return 8'hFF;
        return etb[2'(tsel - 4)][a[6:0]];
    endfunction

    initial begin
        bit ack;
        int wc0;
        for (int i = 0; i < 128; i++) begin
            lo[i] = 0; elo[i] = 0;
            for (int t = 0; t < 4; t++) begin tbm[t][i] = 0; etb[t][i] = 0; end
        end
        wait_c(5);
        chk(sda_oe == 0 && busact == 0 && we == 0, "R6 reset state", {sda_oe, busact, we}, 0);
        rst_n = 1'b1;
        wait_c(10);

        // R3 basic write, R11/R10 readback
        wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
        wr_txn(8'hB0, 8'h10, 2);
        rbuf[0] = 8'h5A; rbuf[1] = 8'hA5;
        rd_txn(8'hB0, 8'h10, 2, "R10 R3 readback");

        // R4 ten bytes from 1Eh: last eight survive in page 18h
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(i + 1);
        wr_txn(8'hB0, 8'h1E, 10);
        for (int i = 0; i < 8; i++) rbuf[i] = emem(8'(8'h18 + i));
        chk(rbuf[0] == 8'd3 && rbuf[6] == 8'd9, "R4 model page", rbuf[0], 3);
        rd_txn(8'hB0, 8'h18, 8, "R4 page wrap readback");

        // R8 table routing
        tsel = 4'd5; wbuf[0] = 8'h77; wr_txn(8'hB0, 8'h85, 1);
        tsel = 4'd6; wbuf[0] = 8'h99; wr_txn(8'hB0, 8'h85, 1);
        tsel = 4'd5; rbuf[0] = 8'h77; rd_txn(8'hB0, 8'h85, 1, "R8 table 5 read");
        tsel = 4'd6; rbuf[0] = 8'h99; rd_txn(8'hB0, 8'h85, 1, "R8 table 6 read");
        tsel = 4'd2; wc0 = we_cnt; wbuf[0] = 8'h11; wr_txn(8'hB0, 8'h85, 1);
        chk(we_cnt == wc0, "R8 invalid select drops write", we_cnt, wc0);
        rbuf[0] = 8'hFF; rd_txn(8'hB0, 8'h85, 1, "R8 invalid select reads FF");
        rbuf[0] = 8'h00; rd_txn(8'hB0, 8'h05, 1, "R8 lower half ignores select");
        tsel = 4'd5; rbuf[0] = 8'h77; rd_txn(8'hB0, 8'h85, 1, "R8 table 5 untouched");

        // R5 read wrap FFh -> 00h
        tsel = 4'd4;
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wr_txn(8'hB0, 8'hFE, 2);
        wbuf[0] = 8'hD1; wbuf[1] = 8'hD2; wr_txn(8'hB0, 8'h00, 2);
        rbuf[0] = 8'hC1; rbuf[1] = 8'hC2; rbuf[2] = 8'hD1; rbuf[3] = 8'hD2;
        rd_txn(8'hB0, 8'hFE, 4, "R5 read wrap");

        // R1 address pins
        pins = 2'b11;
        wbuf[0] = 8'h3C; wr_txn(8'hB6, 8'h20, 1);
        rbuf[0] = 8'h3C; rd_txn(8'hB6, 8'h20, 1, "R1 pins 11 readback");
        i_start; wbyte(8'hB0, ack); chk(!ack, "R1 old address refused", ack, 0); i_stop;
        pins = 2'b00;

        // R2 mismatch ignored until START
        wc0 = we_cnt;
        i_start;
        oe_seen = 1'b0;
        wbyte(8'hB2, ack); chk(!ack, "R2 wrong address nack", ack, 0);
        wbyte(8'h30, ack); chk(!ack, "R2 following byte ignored", ack, 0);
        wbyte(8'h44, ack); chk(!ack, "R2 data ignored", ack, 0);
        chk(!oe_seen, "R2 SDA never driven", oe_seen, 0);
        i_stop; wait_c(20);
        chk(we_cnt == wc0, "R2 no writes", we_cnt, wc0);
        rbuf[0] = 8'h00; rd_txn(8'hB0, 8'h30, 1, "R2 location unchanged");

        // R7 busy refuses address
        nvb = 1'b1;
        i_start; wbyte(8'hB0, ack); chk(!ack, "R7 nack while busy", ack, 0); i_stop;
        nvb = 1'b0;
        i_start; wbyte(8'hB0, ack); chk(ack, "R7 ack after busy", ack, 1); i_stop;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_c(150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule